// File: doc/BRIEF.md
# Audio Serial Port Control and Status Registers

This block is the software-facing register file of a two-channel audio serial port. A word-addressed read/write bus reaches eleven 32-bit locations. These are a write-only command word, a mode word, a status word with companion clear and set words, an interrupt enable/disable pair with a readable mask, a receive and a transmit holding register, and a read-only version word. The serializer and the clock generator sit outside this block. They take the mode word, the receive/transmit/clock enable levels and the holding-register streams from it. They return per-channel overrun and underrun pulses, which the block latches as sticky flags.

Command bits come in enable/disable pairs, so software never needs a read-modify-write to start or stop one part. Sticky flags are cleared by writing ones to the clear word and can be forced by writing ones to the set word, which lets software exercise the interrupt path. The single interrupt line is the OR of status ANDed with the mask.

Both sample paths are valid/ready streams. On receive, the block raises `rx_ready` only while the receiver is enabled and its one-entry holding register is empty. It takes a sample on any edge where `rx_valid` and `rx_ready` are both high. It stays full, refusing further samples, until software reads offset 0x20. On transmit, a bus write to offset 0x24 fills the holding register and raises `tx_valid`. Data stays stable until the serializer asserts `tx_ready`. The serializer owns back-pressure on transmit and must report its own overruns and underruns through the pulse inputs.

Top module: `audio_port_csr`

## Requirements
- R1: After reset the mode word and mask read 0, `irq`, `tx_valid`, `rx_ready` and all enables are low, status reads 0x00000020 (only transmit-ready set), and offset 0x28 reads the VERSION parameter.
- R2: A write to offset 0x00 updates the enable levels on the next edge. Bit 0 sets and bit 1 clears the receiver enable. Bit 2 sets and bit 3 clears the clock enable. Bit 4 sets and bit 5 clears the transmitter enable. When both bits of a pair are written together, the enable ends low. Status bit 0 mirrors the receiver enable and status bit 4 the transmitter enable.
- R3: Offset 0x00 reads as 0. Writes to the status (0x08), mask (0x1C) and version (0x28) offsets change nothing.
- R4: A pulse on `rxor_pulse[n]` sets status bit 8+n and summary bit 2. A pulse on `txur_pulse[n]` sets status bit 20+n and summary bit 6. All of these stay set until cleared.
- R5: Writing ones to offset 0x0C clears the matching sticky bits (2, 6, 8..8+NCH-1, 20..20+NCH-1). Writing ones to offset 0x10 sets them. Other bit positions are unaffected. A pulse arriving in the same cycle as a clear leaves the flag set.
- R6: Writing ones to offset 0x14 sets mask bits and writing ones to offset 0x18 clears them. Only bits 1, 2, 5 and 6 can be masked. Offset 0x1C reads the mask.
- R7: `irq` is high exactly when some status bit and the same mask bit are both 1, in the same cycle the status word shows it.
- R8: A sample accepted on the receive stream sets status bit 1 and drops `rx_ready`. Reading offset 0x20 returns the sample (zero-extended) and clears bit 1 on that edge.
- R9: Writing offset 0x24 loads `tx_data`, raises `tx_valid` and clears status bit 5. Data and valid hold until a `tx_valid`/`tx_ready` handshake empties the register and sets bit 5 again.
- R10: Writing bit 7 of offset 0x00 returns every register and flag to its reset value on the next edge. This overrides any other bit in the same write.
- R11: Offset 0x04 is a full 32-bit read/write mode word, driven unchanged on `mode_cfg`.
- R12: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (needed for the receive-holding pop) |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| rx_valid | input | 1 | Receive sample valid |
| rx_ready | output | 1 | Receive holding register can accept |
| rx_data | input | DW | Receive sample |
| tx_valid | output | 1 | Transmit holding register full |
| tx_ready | input | 1 | Serializer takes the transmit sample |
| tx_data | output | DW | Transmit sample |
| rxor_pulse | input | NCH | Per-channel receive overrun pulses |
| txur_pulse | input | NCH | Per-channel transmit underrun pulses |
| rx_enable | output | 1 | Receiver enable level |
| tx_enable | output | 1 | Transmitter enable level |
| clk_enable | output | 1 | Clock generator enable level |
| mode_cfg | output | 32 | Mode word |
| irq | output | 1 | Interrupt request |

## Verification
A wrong sticky flag or mask bit shows on the next status read, and on `irq` within the same cycle the bad state exists. This is why the random phase reads status and compares `irq` after every operation. A broken pair priority or a lost software-reset override shows on the enable pins one edge after the command write. A holding register that loses its full state shows as a wrong `rx_ready`, `tx_valid` or status ready bit right after the edge that should have filled or emptied it.

// File: rtl/apc_pkg.sv
package apc_pkg;
  localparam int AW = 8;
  localparam int BW = 32;

  localparam logic [AW-1:0] OFS_CMD   = 8'h00;
  localparam logic [AW-1:0] OFS_MODE  = 8'h04;
  localparam logic [AW-1:0] OFS_STAT  = 8'h08;
  localparam logic [AW-1:0] OFS_CLR   = 8'h0C;
  localparam logic [AW-1:0] OFS_SET   = 8'h10;
  localparam logic [AW-1:0] OFS_IEN   = 8'h14;
  localparam logic [AW-1:0] OFS_IDIS  = 8'h18;
  localparam logic [AW-1:0] OFS_IMASK = 8'h1C;
  localparam logic [AW-1:0] OFS_RXH   = 8'h20;
  localparam logic [AW-1:0] OFS_TXH   = 8'h24;
  localparam logic [AW-1:0] OFS_VER   = 8'h28;

  // status bit positions
  localparam int SB_RXON  = 0;
  localparam int SB_RXRDY = 1;
  localparam int SB_RXOV  = 2;
  localparam int SB_TXON  = 4;
  localparam int SB_TXRDY = 5;
  localparam int SB_TXUN  = 6;
  localparam int SB_RXCH  = 8;
  localparam int SB_TXCH  = 20;

  localparam int CMD_SWRST = 7;
  localparam int NPAIR     = 3; // rx, clock, tx enable pairs

  localparam logic [BW-1:0] IRQ_CAPABLE = 32'h0000_0066;
endpackage

// File: rtl/apc_cmd.sv
module apc_cmd
  import apc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             cmd_we,
  input  logic [2*NPAIR-1:0] cmd_bits,
  output logic [NPAIR-1:0] en_q
);
  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       en_q[k] <= 1'b0;
      else if (sw_rst)                  en_q[k] <= 1'b0;
      else if (cmd_we && cmd_bits[2*k+1]) en_q[k] <= 1'b0;
      else if (cmd_we && cmd_bits[2*k])   en_q[k] <= 1'b1;
    end

    // R2: disable strobe wins over enable strobe
    a_r2_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_bits[2*k+1]) |=> !en_q[k]);
    // R2: enable alone raises the level
    a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_bits[2*k] && !cmd_bits[2*k+1] && !sw_rst) |=> en_q[k]);
  end
endmodule

// File: rtl/apc_status.sv
module apc_status
  import apc_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          clr_we,
  input  logic          set_we,
  input  logic [BW-1:0] wdata,
  input  logic [NCH-1:0] rxor_pulse,
  input  logic [NCH-1:0] txur_pulse,
  output logic [BW-1:0] sticky
);
  function automatic logic [BW-1:0] sticky_mask();
    logic [BW-1:0] m;
    m = '0;
    m[SB_RXOV] = 1'b1;
    m[SB_TXUN] = 1'b1;
    for (int i = 0; i < NCH; i++) begin
      m[SB_RXCH+i] = 1'b1;
      m[SB_TXCH+i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [BW-1:0] SMASK = sticky_mask();

  logic [BW-1:0] hit, nxt;

  always_comb begin
    hit = '0;
    hit[SB_RXOV] = |rxor_pulse;
    hit[SB_TXUN] = |txur_pulse;
    for (int i = 0; i < NCH; i++) begin
      hit[SB_RXCH+i] = rxor_pulse[i];
      hit[SB_TXCH+i] = txur_pulse[i];
    end
    nxt = sticky;
    if (clr_we) nxt = nxt & ~wdata;
    if (set_we) nxt = nxt | wdata;
    nxt = (nxt | hit) & SMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sticky <= '0;
    else if (sw_rst) sticky <= '0;
    else             sticky <= nxt;
  end

  // R4: a channel pulse leaves its flag and the summary set
  a_r4_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rxor_pulse[0] && !sw_rst) |=> (sticky[SB_RXCH] && sticky[SB_RXOV]));
  a_r4_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (txur_pulse[0] && !sw_rst) |=> (sticky[SB_TXCH] && sticky[SB_TXUN]));
  // R5: a clear with no competing source empties the summary flag
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wdata[SB_RXOV] && !set_we && !(|rxor_pulse)) |=> !sticky[SB_RXOV]);
  // R5: flags with no source or set hold their value
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && !set_we && !sw_rst && !(|rxor_pulse) && !(|txur_pulse)) |=> $stable(sticky));
endmodule

// File: rtl/apc_irq.sv
module apc_irq
  import apc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          en_we,
  input  logic          dis_we,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] status,
  output logic [BW-1:0] mask,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= '0;
    else if (sw_rst) mask <= '0;
    else if (dis_we) mask <= mask & ~wdata;
    else if (en_we)  mask <= mask | (wdata & IRQ_CAPABLE);
  end

  assign irq = |(status & mask);

  // R6: only interrupt-capable bits ever appear in the mask
  a_r6_mask_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~IRQ_CAPABLE) == '0);
  // R6: a disable write clears every written bit
  a_r6_disable: assert property (@(posedge clk) disable iff (!rst_n)
    dis_we |=> ((mask & $past(wdata)) == '0));
  // R7: a masked pending overrun raises the line
  a_r7_irq_rxov: assert property (@(posedge clk) disable iff (!rst_n)
    (status[SB_RXOV] && mask[SB_RXOV]) |-> irq);
endmodule

// File: rtl/apc_hold.sv
module apc_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          rx_en,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_pop,
  output logic          rx_full,
  output logic [DW-1:0] rx_q,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_q
);
  assign rx_ready = rx_en & ~rx_full;
  assign tx_valid = tx_q_full;

  logic tx_q_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_q    <= '0;
    end else if (sw_rst) begin
      rx_full <= 1'b0;
      rx_q    <= '0;
    end else if (rx_valid && rx_ready) begin
      rx_full <= 1'b1;
      rx_q    <= rx_data;
    end else if (rx_pop) begin
      rx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q_full <= 1'b0;
      tx_q      <= '0;
    end else if (sw_rst) begin
      tx_q_full <= 1'b0;
      tx_q      <= '0;
    end else if (tx_push) begin
      tx_q_full <= 1'b1;
      tx_q      <= tx_wdata;
    end else if (tx_q_full && tx_ready) begin
      tx_q_full <= 1'b0;
    end
  end

  // R8: a full receive register keeps its sample until popped
  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_pop && !sw_rst) |=> (rx_full && $stable(rx_q)));
  // R9: a stalled transmit sample stays valid and stable
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_push && !sw_rst) |=> (tx_valid && $stable(tx_q)));
endmodule

// File: rtl/audio_port_csr.sv
module audio_port_csr
  import apc_pkg::*;
#(
  parameter int          NCH     = 2,
  parameter int          DW      = 32,
  parameter logic [31:0] VERSION = 32'h0001_0300
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic           bus_re,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic           rx_valid,
  output logic           rx_ready,
  input  logic [DW-1:0]  rx_data,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [DW-1:0]  tx_data,
  input  logic [NCH-1:0] rxor_pulse,
  input  logic [NCH-1:0] txur_pulse,
  output logic           rx_enable,
  output logic           tx_enable,
  output logic           clk_enable,
  output logic [31:0]    mode_cfg,
  output logic           irq
);
  logic wr_cmd, sw_rst;
  logic [NPAIR-1:0] en_q;
  logic [BW-1:0] sticky, status, mask, rx_word;
  logic rx_full;
  logic [DW-1:0] rx_q;

  assign wr_cmd = bus_we && (bus_addr == OFS_CMD);
  assign sw_rst = wr_cmd && bus_wdata[CMD_SWRST];

  assign rx_enable  = en_q[0];
  assign clk_enable = en_q[1];
  assign tx_enable  = en_q[2];

  apc_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cmd_we(wr_cmd),
    .cmd_bits(bus_wdata[2*NPAIR-1:0]), .en_q(en_q)
  );

  apc_status #(.NCH(NCH)) u_stat (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .clr_we(bus_we && (bus_addr == OFS_CLR)),
    .set_we(bus_we && (bus_addr == OFS_SET)),
    .wdata(bus_wdata), .rxor_pulse(rxor_pulse), .txur_pulse(txur_pulse),
    .sticky(sticky)
  );

  apc_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .rx_en(en_q[0]),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_pop(bus_re && (bus_addr == OFS_RXH)),
    .rx_full(rx_full), .rx_q(rx_q),
    .tx_push(bus_we && (bus_addr == OFS_TXH)), .tx_wdata(bus_wdata[DW-1:0]),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_q(tx_data)
  );

  always_comb begin
    status = sticky;
    status[SB_RXON]  = en_q[0];
    status[SB_RXRDY] = rx_full;
    status[SB_TXON]  = en_q[2];
    status[SB_TXRDY] = ~tx_valid;
  end

  apc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
    .en_we(bus_we && (bus_addr == OFS_IEN)),
    .dis_we(bus_we && (bus_addr == OFS_IDIS)),
    .wdata(bus_wdata), .status(status), .mask(mask), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 mode_cfg <= '0;
    else if (sw_rst)                            mode_cfg <= '0;
    else if (bus_we && (bus_addr == OFS_MODE))  mode_cfg <= bus_wdata;
  end

  always_comb begin
    rx_word = '0;
    rx_word[DW-1:0] = rx_q;
  end

  always_comb begin
    unique case (bus_addr)
      OFS_MODE:  bus_rdata = mode_cfg;
      OFS_STAT:  bus_rdata = status;
      OFS_IMASK: bus_rdata = mask;
      OFS_RXH:   bus_rdata = rx_word;
      OFS_VER:   bus_rdata = VERSION;
      default:   bus_rdata = '0;
    endcase
  end

  // R10: software reset clears configuration and enables on the next edge
  a_r10_swrst: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (mode_cfg == '0 && mask == '0 && !rx_enable && !tx_enable && !clk_enable && !tx_valid));
  // R11: mode word follows a write on the next edge
  a_r11_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_MODE) |=> (mode_cfg == $past(bus_wdata)));
  // R3: the command offset never returns data
  a_r3_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CMD) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_audio_port_csr.sv
module sim_audio_port_csr;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int DW  = 32;
  localparam logic [31:0] VER = 32'h0001_0300;
  localparam logic [31:0] STICKY = 32'h0030_0344;
  localparam logic [31:0] IRQB   = 32'h0000_0066;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0, bus_re = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic rx_valid = 0, rx_ready, tx_valid, tx_ready = 0;
  logic [DW-1:0] rx_data = 0, tx_data;
  logic [NCH-1:0] rxor_pulse = 0, txur_pulse = 0;
  logic rx_enable, tx_enable, clk_enable, irq;
  logic [31:0] mode_cfg;

  int nchk = 0, nfail = 0;
  logic [31:0] sm, mk, rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_port_csr #(.NCH(NCH), .DW(DW), .VERSION(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rxor_pulse(rxor_pulse), .txur_pulse(txur_pulse), .rx_enable(rx_enable),
    .tx_enable(tx_enable), .clk_enable(clk_enable), .mode_cfg(mode_cfg), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_addr = 8'hFC;
  endtask

  task automatic rdw(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_re = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_re = 0; bus_addr = 8'hFC;
  endtask

  task automatic pulse(input logic [NCH-1:0] r, input logic [NCH-1:0] t);
    @(negedge clk); rxor_pulse = r; txur_pulse = t;
    @(negedge clk); rxor_pulse = 0; txur_pulse = 0;
  endtask

  function automatic logic [31:0] pulse_bits(input logic [NCH-1:0] r, input logic [NCH-1:0] t);
    logic [31:0] b;
    b = '0;
    b[2] = |r; b[6] = |t;
    for (int i = 0; i < NCH; i++) begin b[8+i] = r[i]; b[20+i] = t[i]; end
    return b;
  endfunction

  function automatic logic exp_irq(input logic [31:0] st, input logic [31:0] m);
    return |(st & m);
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    #1;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 0);
    chk("R1 enables", {29'b0, rx_enable, clk_enable, tx_enable}, 0);
    rdw(8'h08, rd); chk("R1 status", rd, 32'h20);
    rdw(8'h04, rd); chk("R1 mode", rd, 0);
    rdw(8'h1C, rd); chk("R1 mask", rd, 0);
    rdw(8'h28, rd); chk("R1 version", rd, VER);

    // R11 mode word
    wr(8'h04, 32'hA5C3_1234);
    rdw(8'h04, rd); chk("R11 mode readback", rd, 32'hA5C3_1234);
    chk("R11 mode_cfg port", mode_cfg, 32'hA5C3_1234);

    // R2 command pairs
    wr(8'h00, 32'h15);
    chk("R2 enables set", {29'b0, rx_enable, clk_enable, tx_enable}, 3'b111);
    rdw(8'h08, rd); chk("R2 status enables", rd, 32'h31);
    wr(8'h00, 32'h03);
    chk("R2 rx disable wins", {31'b0, rx_enable}, 0);
    wr(8'h00, 32'h08);
    chk("R2 clk disable", {31'b0, clk_enable}, 0);
    chk("R2 tx unaffected", {31'b0, tx_enable}, 1);
    wr(8'h00, 32'h30);
    chk("R2 tx disable wins", {31'b0, tx_enable}, 0);

    // R3 read-only and write-only offsets
    rdw(8'h00, rd); chk("R3 cmd reads zero", rd, 0);
    wr(8'h08, 32'hFFFF_FFFF);
    rdw(8'h08, rd); chk("R3 status write ignored", rd, 32'h20);
    wr(8'h1C, 32'hFFFF_FFFF);
    rdw(8'h1C, rd); chk("R3 mask offset write ignored", rd, 0);
    wr(8'h28, 32'h0);
    rdw(8'h28, rd); chk("R3 version write ignored", rd, VER);

    // R12 unmapped
    rdw(8'h2C, rd); chk("R12 unmapped 2C", rd, 0);
    rdw(8'h40, rd); chk("R12 unmapped 40", rd, 0);

    // R8 receive stream
    wr(8'h00, 32'h01);
    #1 chk("R8 rx_ready when empty", {31'b0, rx_ready}, 1);
    @(negedge clk); rx_valid = 1; rx_data = 32'hDEAD_BEEF;
    @(negedge clk); rx_valid = 0; rx_data = 32'h1111_1111;
    chk("R8 rx_ready drops when full", {31'b0, rx_ready}, 0);
    rdw(8'h08, rd); chk("R8 rx ready status", rd & 32'h2, 32'h2);
    @(negedge clk); rx_valid = 1; rx_data = 32'h2222_2222;
    @(negedge clk); rx_valid = 0;
    rdw(8'h20, rd); chk("R8 oldest sample kept", rd, 32'hDEAD_BEEF);
    rdw(8'h08, rd); chk("R8 ready cleared by read", rd & 32'h2, 0);
    #1 chk("R8 rx_ready after pop", {31'b0, rx_ready}, 1);

    // R9 transmit stream
    wr(8'h24, 32'h0000_1234);
    chk("R9 tx_valid", {31'b0, tx_valid}, 1);
    chk("R9 tx_data", tx_data, 32'h1234);
    rdw(8'h08, rd); chk("R9 txrdy cleared", rd & 32'h20, 0);
    repeat (3) @(negedge clk);
    chk("R9 stall holds data", tx_data, 32'h1234);
    chk("R9 stall holds valid", {31'b0, tx_valid}, 1);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    chk("R9 handshake empties", {31'b0, tx_valid}, 0);
    rdw(8'h08, rd); chk("R9 txrdy set again", rd & 32'h20, 32'h20);

    // R6 / R7 mask and interrupt
    wr(8'h00, 32'h02);
    wr(8'h14, 32'hFFFF_FFFF);
    rdw(8'h1C, rd); chk("R6 mask only capable bits", rd, IRQB);
    #1 chk("R7 irq from txrdy", {31'b0, irq}, 1);
    wr(8'h18, 32'h20);
    rdw(8'h1C, rd); chk("R6 disable clears", rd, 32'h46);
    #1 chk("R7 irq low when nothing pending", {31'b0, irq}, 0);
    pulse(2'b10, 2'b00);
    rdw(8'h08, rd); chk("R4 rx channel 1 flag", rd, 32'h224);
    #1 chk("R7 irq on overrun", {31'b0, irq}, 1);
    repeat (2) @(negedge clk);
    rdw(8'h08, rd); chk("R4 flag sticky", rd, 32'h224);
    wr(8'h0C, 32'h204);
    #1 chk("R7 irq after clear", {31'b0, irq}, 0);
    rdw(8'h08, rd); chk("R5 clear", rd, 32'h20);

    // R5 pulse wins over clear in the same cycle
    @(negedge clk); bus_we = 1; bus_addr = 8'h0C; bus_wdata = 32'h104; rxor_pulse = 2'b01;
    @(negedge clk); bus_we = 0; bus_addr = 8'hFC; rxor_pulse = 0;
    rdw(8'h08, rd); chk("R5 pulse beats clear", rd, 32'h124);

    // random phase from a software-reset baseline
    wr(8'h00, 32'h80);
    sm = 0; mk = 0;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      logic [1:0] r, t;
      int op;
      op = $urandom % 5; d = $urandom; r = $urandom; t = $urandom;
      case (op)
        0: begin pulse(r, t); sm = sm | pulse_bits(r, t); end
        1: begin wr(8'h0C, d); sm = sm & ~d; end
        2: begin wr(8'h10, d); sm = sm | (d & STICKY); end
        3: begin wr(8'h14, d); mk = mk | (d & IRQB); end
        default: begin wr(8'h18, d); mk = mk & ~d; end
      endcase
      rdw(8'h08, rd); chk("R4 R5 random status", rd, (sm & STICKY) | 32'h20);
      #1 chk("R7 random irq", {31'b0, irq}, {31'b0, exp_irq((sm & STICKY) | 32'h20, mk)});
      if (op >= 3) begin
        rdw(8'h1C, rd); chk("R6 random mask", rd, mk);
      end
    end

    // R10 software reset overrides other command bits
    wr(8'h04, 32'h1234_5678);
    wr(8'h14, 32'h66);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h24, 32'hCAFE);
    wr(8'h00, 32'h04);
    wr(8'h00, 32'h91);
    chk("R10 enables", {29'b0, rx_enable, clk_enable, tx_enable}, 0);
    chk("R10 tx_valid", {31'b0, tx_valid}, 0);
    chk("R10 mode_cfg", mode_cfg, 0);
    #1 chk("R10 irq", {31'b0, irq}, 0);
    rdw(8'h08, rd); chk("R10 status", rd, 32'h20);
    rdw(8'h1C, rd); chk("R10 mask", rd, 0);

    finish_run();
  end
endmodule